// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a W-bit dividend by a W-bit divisor over several clock cycles. It runs as either an unsigned or a two's-complement signed divider. A single unsigned core does the work. It keeps the partial remainder and the growing quotient in one shared shift register, which is one bit wider than 2W. The core performs one trial subtraction per cycle. A subtraction that succeeds keeps the difference and shifts in a 1. A subtraction that fails keeps the old partial remainder and shifts in a 0. The register is shifted once before the first trial. For that reason, the remainder half is shifted back by one position when the quotient is read out.

For signed operation, both operands are first reduced to magnitudes. After the unsigned core finishes:
- the quotient is negated when the operand signs differ;
- the remainder is given the sign of the dividend.

A zero divisor bypasses the core and completes on the next cycle.

Operands enter through a valid/ready handshake. An operand set is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time a division is in progress, and no other condition stalls the input. While `in_ready` is low, the operand inputs are ignored. The result side has no back-pressure. `done` marks the cycle in which new results appear, and the results stay on the outputs until the next completion.

Top module: `seq_divider`

## Requirements
- R1: `in_ready` is high when no division is in progress. A cycle with `in_valid` high and `in_ready` low has no effect on any output.
- R2: With `signed_op` low and a non-zero divisor, `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor, both unsigned. `done` rises exactly W+1 clock edges after the edge that accepted the operands.
- R3: With `signed_op` high and a non-zero divisor, `quotient` is the two's-complement quotient truncated toward zero. `remainder` carries the dividend's sign, so that dividend = quotient*divisor + remainder (for example, -7 by 2 gives -3 remainder -1). The timing is the same as in R2.
- R4: A zero divisor sets `div_zero`, makes `quotient` all ones and makes `remainder` equal the raw dividend, in either mode. `done` rises on the edge after acceptance.
- R5: A signed division of the most negative value by -1 returns the most negative value as `quotient` and zero as `remainder`, with `div_zero` low.
- R6: `done` is high for one cycle for each accepted operation. `quotient`, `remainder` and `div_zero` change only in a cycle where `done` is high.
- R7: After reset: `in_ready` is 1, `done` is 0, and `quotient`, `remainder` and `div_zero` are 0.
- R8: `div_zero` is cleared by the completion of any division whose divisor is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Divider is idle and will take operands |
| dividend | input | W | Dividend |
| divisor | input | W | Divisor |
| signed_op | input | 1 | 1: two's-complement operands, 0: unsigned |
| done | output | 1 | One-cycle pulse: results updated |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| div_zero | output | 1 | The last completed operation had a zero divisor |

## Verification
Two events can fall in the same cycle: the completion pulse of one division and the acceptance of the next operand set. This is the central overlap. The bench provokes it by holding `in_valid` high across a completion, including a case where the next operation has a zero divisor. That case makes `done` high on two consecutive cycles.

A cycle-by-cycle reference model predicts `in_ready`, `done` and every result bit on every clock. In the overlap case, the bench judges that the finishing result is not disturbed by the new acceptance. It also judges that the new result arrives on its own schedule. The same model covers operands offered while the divider is busy, and confirms that such operands have no effect.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_mag.sv
module div_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         sgn,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = sgn & val[W-1];
    mag = neg ? (~val + 1'b1) : val;
  end
endmodule

// File: rtl/div_core.sv
module div_core
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam int AW = 2 * W + 1;

  div_state_e     state;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  acc;
  logic [W-1:0]   dvs_q;
  logic [W:0]     upper;
  logic [W+1:0]   diff;
  logic           take;
  logic [AW-1:0]  kept;

  always_comb begin
    upper = acc[AW-1:W];
    diff  = {1'b0, upper} - {2'b0, dvs_q};
    take  = ~diff[W+1];
    kept  = take ? {diff[W:0], acc[W-1:0]} : acc;
  end

  assign busy = (state == ST_RUN);
  assign fin  = busy && (cnt == CW'(W));
  assign quo  = acc[W-1:0];
  assign rem  = acc[AW-1:W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      acc   <= '0;
      dvs_q <= '0;
    end else if (state == ST_IDLE) begin
      if (load) begin
        state <= ST_RUN;
        cnt   <= '0;
        acc   <= {{W{1'b0}}, dvd, 1'b0};
        dvs_q <= dvs;
      end
    end else if (cnt == CW'(W)) begin
      state <= ST_IDLE;
    end else begin
      acc <= {kept[AW-2:0], take};
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the working remainder never reaches twice the divisor
  a_r2_partial_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, upper} < ({2'b0, dvs_q} << 1)));

  // R1: no new load is taken while a division runs
  a_r1_run_holds_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(dvs_q));
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] uq,
  input  logic [W-1:0] ur,
  input  logic         neg_q,
  input  logic         neg_r,
  output logic [W-1:0] q,
  output logic [W-1:0] r
);
  always_comb begin
    q = neg_q ? (~uq + 1'b1) : uq;
    r = neg_r ? (~ur + 1'b1) : ur;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         signed_op,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  logic [W-1:0] dvd_mag, dvs_mag, uq, ur, fq, fr;
  logic         dvd_neg, dvs_neg, accept, zero_in;
  logic         core_busy, core_fin;
  logic         neg_q_r, neg_r_r, sgn_r;

  div_mag #(.W(W)) u_mag_dvd (.val(dividend), .sgn(signed_op), .mag(dvd_mag), .neg(dvd_neg));
  div_mag #(.W(W)) u_mag_dvs (.val(divisor),  .sgn(signed_op), .mag(dvs_mag), .neg(dvs_neg));

  assign in_ready = ~core_busy;
  assign accept   = in_valid & in_ready;
  assign zero_in  = (divisor == '0);

  div_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept & ~zero_in),
    .dvd(dvd_mag), .dvs(dvs_mag),
    .busy(core_busy), .fin(core_fin), .quo(uq), .rem(ur)
  );

  div_fix #(.W(W)) u_fix (
    .uq(uq), .ur(ur), .neg_q(neg_q_r), .neg_r(neg_r_r), .q(fq), .r(fr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q_r   <= 1'b0;
      neg_r_r   <= 1'b0;
      sgn_r     <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && zero_in) begin
        done      <= 1'b1;
        quotient  <= '1;
        remainder <= dividend;
        div_zero  <= 1'b1;
      end else if (accept) begin
        neg_q_r <= dvd_neg ^ dvs_neg;
        neg_r_r <= dvd_neg;
        sgn_r   <= signed_op;
      end else if (core_fin) begin
        done      <= 1'b1;
        quotient  <= fq;
        remainder <= fr;
        div_zero  <= 1'b0;
      end
    end
  end

  // R6: results move only with a completion pulse
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  // R6: a core completion is followed by at most a zero-divisor completion
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |=> (!done || div_zero));

  // R4: zero-divisor result carries an all-ones quotient
  a_r4_dz_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == '1));

  // R3: signed remainder follows the dividend sign
  a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && sgn_r && (remainder != '0)) |-> (remainder[W-1] == neg_r_r));

  // R2: a core result is only produced after a busy cycle
  a_r2_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> $past(!in_ready));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         signed_op = 1'b0;
  logic         done;
  logic [W-1:0] quotient, remainder;
  logic         div_zero;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  seq_divider #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .signed_op(signed_op),
    .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  // reference model state
  int           busy_cnt = 0;
  logic         exp_done = 1'b0;
  logic [W-1:0] exp_q = '0, exp_r = '0;
  logic         exp_dz = 1'b0;
  logic [W-1:0] pend_q, pend_r;
  string        pend_tag = "R2";
  string        last_tag = "R7";

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic s, output logic [W-1:0] q,
                                output logic [W-1:0] r, output string tag);
    longint sa, sb, lq, lr;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      lq = sa / sb;
      lr = sa % sb;
      q = lq[W-1:0];
      r = lr[W-1:0];
      tag = (a == {1'b1, {(W-1){1'b0}}} && b == '1) ? "R5" : "R3";
    end else begin
      q = a / b;
      r = a % b;
      tag = "R2";
    end
  endfunction

  always @(posedge clk) begin
    logic acc;
    acc = in_valid && in_ready && rst_n;
    exp_done = 1'b0;
    if (rst_n) begin
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) begin
          exp_done = 1'b1;
          exp_q = pend_q;
          exp_r = pend_r;
          exp_dz = 1'b0;
          last_tag = pend_tag;
        end
      end
      if (acc) begin
        if (divisor == '0) begin
          exp_done = 1'b1;
          exp_q = '1;
          exp_r = dividend;
          exp_dz = 1'b1;
          last_tag = "R4";
        end else begin
          model(dividend, divisor, signed_op, pend_q, pend_r, pend_tag);
          busy_cnt = W + 1;
        end
      end
    end
    #1;
    if (rst_n) begin
      chk("R1 ready", {31'b0, in_ready}, {31'b0, (busy_cnt == 0)});
      chk("R6 done", {31'b0, done}, {31'b0, exp_done});
      if (exp_done) begin
        chk({last_tag, " quotient"}, quotient, exp_q);
        chk({last_tag, " remainder"}, remainder, exp_r);
        chk(exp_dz ? "R4 flag" : "R8 flag", {31'b0, div_zero}, {31'b0, exp_dz});
      end else begin
        chk("R6 hold", quotient ^ remainder ^ {31'b0, div_zero},
            exp_q ^ exp_r ^ {31'b0, exp_dz});
      end
    end
  end

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; dividend = a; divisor = b; signed_op = s;
    @(negedge clk);
    in_valid = 1'b0;
    dividend = $urandom; divisor = $urandom;
  endtask

  task automatic settle();
    repeat (W + 4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 ready", {31'b0, in_ready}, 32'd1);
    chk("R7 done", {31'b0, done}, 32'd0);
    chk("R7 quotient", quotient, '0);
    chk("R7 remainder", remainder, '0);
    chk("R7 flag", {31'b0, div_zero}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unsigned corners
    op(32'd7, 32'd2, 1'b0);
    op(32'd0, 32'd5, 1'b0);
    op(32'hFFFF_FFFF, 32'd1, 1'b0);
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    op(32'h8000_0001, 32'hFFFF_FFFE, 1'b0);
    op(32'd3, 32'd10, 1'b0);
    // R3 signed sign combinations
    op(-32'sd7, 32'd2, 1'b1);
    op(32'd7, -32'sd2, 1'b1);
    op(-32'sd7, -32'sd2, 1'b1);
    op(32'h8000_0000, 32'd3, 1'b1);
    // R5 most negative by -1
    op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    // R4 zero divisor both modes, then R8 clear
    op(32'h1234_5678, 32'd0, 1'b0);
    op(-32'sd9, 32'd0, 1'b1);
    op(32'd100, 32'd7, 1'b0);
    settle();

    // R1: operands offered while busy are ignored
    op(32'd1000, 32'd3, 1'b0);
    repeat (5) begin
      @(negedge clk);
      in_valid = 1'b1; dividend = 32'd77; divisor = 32'd0;
    end
    in_valid = 1'b0;
    settle();

    // overlap: hold valid so a new operand set is taken in the done cycle
    @(negedge clk);
    in_valid = 1'b1; dividend = 32'd50; divisor = 32'd6; signed_op = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    dividend = 32'd11; divisor = 32'd0;
    @(negedge clk);
    dividend = -32'sd20; divisor = 32'd3; signed_op = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    settle();

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 4 == 0) ? ($urandom & 32'hFF) : $urandom;
      if (i % 16 == 5) b = '0;
      op(a, b, i[0]);
    end
    settle();

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule